// File: doc/BRIEF.md
# Bidirectional Data Bus Buffer

This block sits between a processor's internal data bus and the external three-state data pins. The timing unit gives it three controls: the kind of the current state, whether a data transfer is active, and the transfer direction. In output transfers the internal bus value is captured into a holding register that drives the external pins. In input transfers the external data is forwarded onto the internal bus.

Outside transfer states the internal bus is precharged. This is modelled as the internal bus reading a fixed precharge value (all ones by default) during the first phase of each such state. In the second phase the value placed by the internal drivers shows through. The two transfer states (T3 and wait) are never precharged.

Top module: `dbus_buffer`

## Requirements
- R1: While reset is asserted, `ext_oe` is 0 and `ext_dout` is 0.
- R2: In a transfer state (`st_kind` = 2'b01 for T3 or 2'b10 for wait), with `xfer_en`=1 and `dir_out`=1, the value of `ibus_drv` at the rising clock edge appears on `ext_dout`, with `ext_oe`=1, from that edge on.
- R3: After an edge at which a transfer state has `xfer_en`=1 and `dir_out`=0 (input), `ext_oe` is 0.
- R4: After an edge at which the state is not a transfer state (`st_kind` 2'b00 or 2'b11), or `xfer_en`=0, `ext_oe` is 0.
- R5: In a transfer state with `xfer_en`=1 and `dir_out`=0, `ibus_out` equals `ext_din` in the same cycle.
- R6: In a non-transfer state with `phase_first`=1, `ibus_out` equals the precharge value (all ones by default).
- R7: In a non-transfer state with `phase_first`=0, `ibus_out` equals `ibus_drv`.
- R8: `ext_dout` keeps its value across every edge that is not an output-transfer load, including while `ext_oe` is 0 and during input transfers.
- R9: No precharge happens in a transfer state. With `phase_first`=1 and no input transfer, `ibus_out` equals `ibus_drv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_kind | input | 2 | 00 ordinary, 01 T3, 10 wait, 11 ordinary |
| phase_first | input | 1 | High during the first phase of a state |
| xfer_en | input | 1 | A data transfer is active |
| dir_out | input | 1 | 1 = output transfer, 0 = input transfer |
| ibus_drv | input | 8 | Value placed by internal bus drivers |
| ibus_out | output | 8 | Resolved internal bus value |
| ext_din | input | 8 | Value sensed on external pins |
| ext_dout | output | 8 | Holding-register value for the pins |
| ext_oe | output | 1 | Output buffer enable |

## Verification
A wrong holding register shows on `ext_dout` one edge after the load, and it stays wrong through every later idle and input cycle until the next output load. A wrong enable state shows on `ext_oe` one edge after the controls change. A precharge or input-path fault is combinational, so `ibus_out` is wrong in the same cycle in which the state kind and phase are applied.

// File: rtl/dbus_buffer_pkg.sv
package dbus_buffer_pkg;
   typedef enum logic [1:0] {
      ST_PLAIN = 2'b00,
      ST_T3    = 2'b01,
      ST_WAIT  = 2'b10,
      ST_SPARE = 2'b11
   } st_kind_e;

   function automatic logic is_xfer_state(input logic [1:0] k);
      return (k == ST_T3) || (k == ST_WAIT);
   endfunction
endpackage

// File: rtl/dbus_out_hold.sv
module dbus_out_hold #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic             oe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q  <= '0;
         oe <= 1'b0;
      end else begin
         oe <= load;
         if (load) q <= d;
      end
   end
endmodule

// File: rtl/dbus_ibus_mux.sv
module dbus_ibus_mux #(
   parameter int               WIDTH     = 8,
   parameter logic [WIDTH-1:0] PRE_VALUE = '1
) (
   input  logic             sel_ext,
   input  logic             sel_pre,
   input  logic [WIDTH-1:0] drv,
   input  logic [WIDTH-1:0] ext,
   output logic [WIDTH-1:0] bus
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_comb begin
         if (sel_ext)      bus[b] = ext[b];
         else if (sel_pre) bus[b] = PRE_VALUE[b];
         else              bus[b] = drv[b];
      end
   end
endmodule

// File: rtl/dbus_buffer.sv
module dbus_buffer #(
   parameter int               WIDTH     = 8,
   parameter logic [WIDTH-1:0] PRE_VALUE = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       st_kind,
   input  logic             phase_first,
   input  logic             xfer_en,
   input  logic             dir_out,
   input  logic [WIDTH-1:0] ibus_drv,
   output logic [WIDTH-1:0] ibus_out,
   input  logic [WIDTH-1:0] ext_din,
   output logic [WIDTH-1:0] ext_dout,
   output logic             ext_oe
);
   import dbus_buffer_pkg::*;

   if (WIDTH < 1) begin : g_bad_width
      $error("dbus_buffer: WIDTH must be at least 1");
   end

   logic in_xfer;
   logic do_load;
   logic do_input;
   logic do_pre;

   assign in_xfer  = is_xfer_state(st_kind);
   assign do_load  = in_xfer && xfer_en && dir_out;
   assign do_input = in_xfer && xfer_en && !dir_out;
   assign do_pre   = !in_xfer && phase_first;

   dbus_out_hold #(.WIDTH(WIDTH)) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .load (do_load),
      .d    (ibus_drv),
      .q    (ext_dout),
      .oe   (ext_oe)
   );

   dbus_ibus_mux #(.WIDTH(WIDTH), .PRE_VALUE(PRE_VALUE)) u_mux (
      .sel_ext(do_input),
      .sel_pre(do_pre),
      .drv    (ibus_drv),
      .ext    (ext_din),
      .bus    (ibus_out)
   );
endmodule

// File: rtl/dbus_buffer_chk.sv
module dbus_buffer_chk #(
   parameter int               WIDTH     = 8,
   parameter logic [WIDTH-1:0] PRE_VALUE = '1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       st_kind,
   input logic             phase_first,
   input logic             xfer_en,
   input logic             dir_out,
   input logic [WIDTH-1:0] ibus_drv,
   input logic [WIDTH-1:0] ibus_out,
   input logic [WIDTH-1:0] ext_din,
   input logic [WIDTH-1:0] ext_dout,
   input logic             ext_oe
);
   logic xf;
   assign xf = (st_kind == 2'b01) || (st_kind == 2'b10);

   always_comb begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (!ext_oe && ext_dout == '0);
      end
   end

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (xf && xfer_en && dir_out) |=> (ext_oe && ext_dout == $past(ibus_drv)));

   p_oe_off_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xf && xfer_en && !dir_out) |=> !ext_oe);

   p_oe_off_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!xf || !xfer_en) |=> !ext_oe);

   p_pass_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xf && xfer_en && !dir_out) |-> (ibus_out == ext_din));

   p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!xf && phase_first) |-> (ibus_out == PRE_VALUE));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(xf && xfer_en && dir_out) |=> $stable(ext_dout));

   p_no_pre_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (xf && !(xfer_en && !dir_out)) |-> (ibus_out == ibus_drv));
endmodule

bind dbus_buffer dbus_buffer_chk #(.WIDTH(WIDTH), .PRE_VALUE(PRE_VALUE)) u_chk (
   .clk(clk), .rst_n(rst_n), .st_kind(st_kind), .phase_first(phase_first),
   .xfer_en(xfer_en), .dir_out(dir_out), .ibus_drv(ibus_drv),
   .ibus_out(ibus_out), .ext_din(ext_din), .ext_dout(ext_dout), .ext_oe(ext_oe)
);

// File: tb/dbus_buffer_bench.sv
module dbus_buffer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] st_kind = 2'b00;
   logic       phase_first = 1'b0;
   logic       xfer_en = 1'b0;
   logic       dir_out = 1'b0;
   logic [7:0] ibus_drv = 8'h00;
   logic [7:0] ext_din = 8'h00;
   logic [7:0] ibus_out;
   logic [7:0] ext_dout;
   logic       ext_oe;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   dbus_buffer u_dbus_buffer (
      .clk(clk), .rst_n(rst_n), .st_kind(st_kind), .phase_first(phase_first),
      .xfer_en(xfer_en), .dir_out(dir_out), .ibus_drv(ibus_drv),
      .ibus_out(ibus_out), .ext_din(ext_din), .ext_dout(ext_dout), .ext_oe(ext_oe)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] k, input logic ph, input logic en,
                        input logic dout, input logic [7:0] drv, input logic [7:0] din);
      st_kind = k; phase_first = ph; xfer_en = en; dir_out = dout;
      ibus_drv = drv; ext_din = din;
      #1;
   endtask

   task automatic t_reset();
      #1;
      check(ext_oe == 1'b0, "R1 oe", int'(ext_oe), 0);
      check(ext_dout == 8'h00, "R1 dout", int'(ext_dout), 0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_output();
      drive(2'b01, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h00);
      @(negedge clk);
      check(ext_oe == 1'b1, "R2 oe", int'(ext_oe), 1);
      check(ext_dout == 8'hA5, "R2 dout", int'(ext_dout), 'hA5);
      drive(2'b00, 1'b0, 1'b0, 1'b0, 8'h11, 8'h00);
      @(negedge clk);
      check(ext_oe == 1'b0, "R4 oe idle", int'(ext_oe), 0);
      check(ext_dout == 8'hA5, "R8 hold idle", int'(ext_dout), 'hA5);
      drive(2'b11, 1'b0, 1'b1, 1'b1, 8'h22, 8'h00);
      @(negedge clk);
      check(ext_oe == 1'b0, "R4 oe spare", int'(ext_oe), 0);
      check(ext_dout == 8'hA5, "R8 hold spare", int'(ext_dout), 'hA5);
   endtask

   task automatic t_input();
      drive(2'b01, 1'b0, 1'b1, 1'b0, 8'h99, 8'h3C);
      check(ibus_out == 8'h3C, "R5 T3", int'(ibus_out), 'h3C);
      @(negedge clk);
      check(ext_oe == 1'b0, "R3 oe", int'(ext_oe), 0);
      check(ext_dout == 8'hA5, "R8 hold input", int'(ext_dout), 'hA5);
      drive(2'b10, 1'b1, 1'b1, 1'b0, 8'h99, 8'hC3);
      check(ibus_out == 8'hC3, "R5 wait", int'(ibus_out), 'hC3);
      @(negedge clk);
   endtask

   task automatic t_precharge();
      drive(2'b00, 1'b1, 1'b0, 1'b0, 8'h12, 8'h34);
      check(ibus_out == 8'hFF, "R6 plain", int'(ibus_out), 'hFF);
      drive(2'b11, 1'b1, 1'b1, 1'b0, 8'h12, 8'h34);
      check(ibus_out == 8'hFF, "R6 spare", int'(ibus_out), 'hFF);
      drive(2'b00, 1'b0, 1'b0, 1'b0, 8'h12, 8'h34);
      check(ibus_out == 8'h12, "R7 second phase", int'(ibus_out), 'h12);
      @(negedge clk);
   endtask

   task automatic t_xfer_no_pre();
      drive(2'b10, 1'b1, 1'b1, 1'b1, 8'h5A, 8'h00);
      check(ibus_out == 8'h5A, "R9 wait out", int'(ibus_out), 'h5A);
      @(negedge clk);
      check(ext_oe == 1'b1, "R2 wait oe", int'(ext_oe), 1);
      check(ext_dout == 8'h5A, "R2 wait dout", int'(ext_dout), 'h5A);
      drive(2'b01, 1'b1, 1'b0, 1'b0, 8'h77, 8'h00);
      check(ibus_out == 8'h77, "R9 T3 no xfer", int'(ibus_out), 'h77);
      @(negedge clk);
      check(ext_oe == 1'b0, "R4 no xfer", int'(ext_oe), 0);
      check(ext_dout == 8'h5A, "R8 hold T3", int'(ext_dout), 'h5A);
   endtask

   initial begin
      t_reset();
      t_output();
      t_input();
      t_precharge();
      t_xfer_no_pre();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #20000;
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule